// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the two divider outputs of a phase-locked loop, the divided reference and the divided feedback, and decides whether the loop is in lock. It runs on a fast sampling clock. On every phase-detector cycle it counts how many sampling periods separate the rising edge of one divider output from the rising edge of the other. The result is either good (small), bad (large) or in between.

A run of consecutive good cycles raises an active-high lock flag. The `precise` input selects how long that run must be: a short run or a long run. Once the flag is high, only a bad cycle clears it, and a bad threshold sits above the good threshold, so the flag has hysteresis. If the second edge of a cycle is late enough to exceed the bad threshold, the cycle is closed early and counted as bad. A power-down input holds the detector cleared. Both thresholds are parameters expressed in sampling-clock periods.

Top module: `lockdet_top`

## Requirements
- R1: After reset `lock` is 0, and it stays 0 until a complete run of good cycles has been seen.
- R2: The error of a cycle is the number of sampling periods from the first sampled rising edge of `ref_div` or `fb_div` to the first rising edge of the other. Either order is accepted. Rising edges of both in the same sampling period give an error of 0.
- R3: A cycle is good when its error is below GOOD_CNT (default 3). With `precise`=0 and `lock`=0, LOW_CYC (default 3) consecutive good cycles set `lock` on the clock edge that samples the last cycle's second edge.
- R4: With `precise`=1, HIGH_CYC (default 5) consecutive good cycles are needed to set `lock`. The value of `precise` at the moment each cycle completes is the one used.
- R5: While `lock` is 0, a cycle whose error is GOOD_CNT or more (mid or bad) restarts the consecutive-good count from zero.
- R6: While `lock` is 1, good cycles and mid cycles (error from GOOD_CNT up to BAD_CNT, default 5) leave it at 1. A single cycle with an error above BAD_CNT clears it.
- R7: If the second edge has not arrived once BAD_CNT sampling periods have elapsed since the first edge, that cycle is closed as a bad cycle. A later edge then starts a new cycle.
- R8: While `pwr_down` is 1, `lock` is forced to 0, the consecutive-good count is cleared, any open measurement is abandoned and divider edges are ignored. After release, a full new run is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Synchronous clear and hold while high |
| precise | input | 1 | 0: short good run needed, 1: long good run needed |
| ref_div | input | 1 | Reference-divider output, synchronous to `clk` |
| fb_div | input | 1 | Feedback-divider output, synchronous to `clk` |
| lock | output | 1 | Active-high lock flag |

## Verification
The assertions check on every cycle that the flag rises only on a completed good cycle and falls only on a bad cycle or power-down. They also check that a mid cycle never drops a held lock, that power-down clears the flag and suppresses results, and that an early-closed cycle is always classed bad. The run lengths of three and five, the reset of the run by a mid cycle, the measurement in both edge orders, and the exact cycle thresholds can only be shown by the bench's pulse scenarios. Those scenarios are compared against a separate model of the classification and the run counter.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    CLS_GOOD = 2'd0,
    CLS_MID  = 2'd1,
    CLS_BAD  = 2'd2
  } phase_cls_e;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } meter_st_e;

  // Sort one completed measurement into good / mid / bad.
  function automatic phase_cls_e classify(input int unsigned err,
                                          input logic        timed_out,
                                          input int unsigned good_lim,
                                          input int unsigned bad_lim);
    if (timed_out || err > bad_lim) return CLS_BAD;
    if (err < good_lim)             return CLS_GOOD;
    return CLS_MID;
  endfunction

  // Length of the good run that declares lock.
  function automatic int unsigned run_needed(input logic        precise,
                                             input int unsigned short_n,
                                             input int unsigned long_n);
    return precise ? long_n : short_n;
  endfunction

endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] sig_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q[i] <= 1'b0;
      else        sig_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~sig_q[i];
  end
endmodule

// File: rtl/lockdet_meter.sv
module lockdet_meter
  import lockdet_pkg::*;
#(
  parameter int BAD_CNT = 5,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             done,
  output logic [CNT_W-1:0] err,
  output logic             timeout
);
  meter_st_e        st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             other_edge;

  assign other_edge = (st == MS_WAIT_FB) ? fb_rise : ref_rise;

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    done    = 1'b0;
    err     = '0;
    timeout = 1'b0;
    if (clr) begin
      st_nx  = MS_IDLE;
      cnt_nx = '0;
    end else begin
      case (st)
        MS_IDLE: begin
          if (ref_rise && fb_rise) begin
            done = 1'b1;
          end else if (ref_rise) begin
            st_nx  = MS_WAIT_FB;
            cnt_nx = CNT_W'(1);
          end else if (fb_rise) begin
            st_nx  = MS_WAIT_REF;
            cnt_nx = CNT_W'(1);
          end
        end
        MS_WAIT_FB, MS_WAIT_REF: begin
          if (other_edge) begin
            done   = 1'b1;
            err    = cnt;
            st_nx  = MS_IDLE;
            cnt_nx = '0;
          end else if (cnt == CNT_W'(BAD_CNT)) begin
            done    = 1'b1;
            timeout = 1'b1;
            err     = cnt;
            st_nx   = MS_IDLE;
            cnt_nx  = '0;
          end else begin
            cnt_nx = cnt + CNT_W'(1);
          end
        end
        default: begin
          st_nx  = MS_IDLE;
          cnt_nx = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= MS_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/lockdet_qual.sv
module lockdet_qual
  import lockdet_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 5,
  parameter int RUN_W    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       precise,
  input  logic       done,
  input  phase_cls_e cls,
  output logic       lock
);
  logic [RUN_W-1:0] run, run_inc, need;

  assign need    = RUN_W'(run_needed(precise, LOW_CYC, HIGH_CYC));
  assign run_inc = run + RUN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      run  <= '0;
    end else if (clr) begin
      lock <= 1'b0;
      run  <= '0;
    end else if (done) begin
      if (lock) begin
        run <= '0;
        if (cls == CLS_BAD) lock <= 1'b0;
      end else if (cls == CLS_GOOD) begin
        if (run_inc >= need) begin
          lock <= 1'b1;
          run  <= '0;
        end else begin
          run <= run_inc;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int GOOD_CNT = 3,
  parameter int BAD_CNT  = 5,
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic precise,
  input  logic ref_div,
  input  logic fb_div,
  output logic lock
);
  localparam int CNT_W = $clog2(BAD_CNT + 2);
  localparam int RUN_W = $clog2(HIGH_CYC + 1);

  logic [1:0]       rise;
  logic             ref_rise, fb_rise;
  logic             meas_done, meas_timeout;
  logic [CNT_W-1:0] meas_err;
  phase_cls_e       meas_cls;
  logic             cls_good, cls_bad;

  lockdet_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({fb_div, ref_div}),
    .rise (rise)
  );
  assign ref_rise = rise[0];
  assign fb_rise  = rise[1];

  lockdet_meter #(.BAD_CNT(BAD_CNT), .CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_down),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .done    (meas_done),
    .err     (meas_err),
    .timeout (meas_timeout)
  );

  assign meas_cls = classify(32'(meas_err), meas_timeout, GOOD_CNT, BAD_CNT);
  assign cls_good = (meas_cls == CLS_GOOD);
  assign cls_bad  = (meas_cls == CLS_BAD);

  lockdet_qual #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .RUN_W(RUN_W)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pwr_down),
    .precise(precise),
    .done   (meas_done),
    .cls    (meas_cls),
    .lock   (lock)
  );
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
  parameter int BAD_CNT = 5,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             lock,
  input logic             meas_done,
  input logic             meas_timeout,
  input logic [CNT_W-1:0] meas_err,
  input logic             cls_good,
  input logic             cls_bad
);
  // R3
  lock_rise_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(meas_done && cls_good && !pwr_down));

  // R6
  lock_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(pwr_down || (meas_done && cls_bad)));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !pwr_down && !(meas_done && cls_bad)) |=> lock);

  // R8
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !lock);

  // R8
  pd_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !meas_done);

  // R7
  timeout_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && meas_timeout) |-> cls_bad);

  // R2
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !meas_timeout) |-> (meas_err <= CNT_W'(BAD_CNT)));
endmodule

bind lockdet_top lockdet_chk #(.BAD_CNT(BAD_CNT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_down    (pwr_down),
  .lock        (lock),
  .meas_done   (meas_done),
  .meas_timeout(meas_timeout),
  .meas_err    (meas_err),
  .cls_good    (cls_good),
  .cls_bad     (cls_bad)
);

// File: tb/lockdet_top_tb.sv
module lockdet_top_tb;
  localparam int GOOD = 3;
  localparam int BAD  = 5;
  localparam int LOWN = 3;
  localparam int HIGHN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic precise = 1'b0;
  logic ref_div = 1'b0;
  logic fb_div = 1'b0;
  logic lock;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int  m_run = 0;
  bit  m_lock = 1'b0;

  always #5 clk = ~clk;

  lockdet_top #(.GOOD_CNT(GOOD), .BAD_CNT(BAD), .LOW_CYC(LOWN), .HIGH_CYC(HIGHN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .precise(precise),
    .ref_div(ref_div), .fb_div(fb_div), .lock(lock)
  );

  // 0 good, 1 mid, 2 bad; a gap beyond BAD means the cycle closes late = bad
  function automatic int grade(input int gap);
    if (gap > BAD)  return 2;
    if (gap < GOOD) return 0;
    return 1;
  endfunction

  function automatic int need_of(input bit p);
    return p ? HIGHN : LOWN;
  endfunction

  task automatic model_apply(input int g);
    if (m_lock) begin
      m_run = 0;
      if (g == 2) m_lock = 1'b0;
    end else if (g == 0) begin
      if (m_run + 1 >= need_of(precise)) begin
        m_lock = 1'b1;
        m_run = 0;
      end else m_run = m_run + 1;
    end else m_run = 0;
  endtask

  task automatic check(input string req, input bit exp);
    n_cmp++;
    if (lock !== exp) begin
      n_bad++;
      $display("FAIL %s: lock=%0b expected=%0b", req, lock, exp);
    end
  endtask

  // one phase-detector cycle: each divider output high for two periods
  task automatic pair(input bit ref_first, input int gap);
    int t_ref = ref_first ? 0 : gap;
    int t_fb  = ref_first ? gap : 0;
    for (int c = 0; c < gap + 2; c++) begin
      @(negedge clk);
      ref_div = (c >= t_ref) && (c < t_ref + 2);
      fb_div  = (c >= t_fb) && (c < t_fb + 2);
    end
    for (int c = 0; c < BAD + 4; c++) begin
      @(negedge clk);
      ref_div = 1'b0;
      fb_div  = 1'b0;
    end
    if (!pwr_down) model_apply(grade(gap));
  endtask

  task automatic pair_chk(input string req, input bit ref_first, input int gap);
    pair(ref_first, gap);
    check(req, m_lock);
  endtask

  task automatic power_down(input int cycles);
    @(negedge clk);
    pwr_down = 1'b1;
    m_lock = 1'b0;
    m_run = 0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0);

    // R3: three good cycles, lock on the third
    pair_chk("R3 good 1", 1'b1, 0);
    pair_chk("R3 good 2", 1'b1, 1);
    pair_chk("R3 good 3", 1'b1, 2);
    // R6: mid cycles hold, exact bad threshold
    pair_chk("R6 mid holds", 1'b1, GOOD);
    pair_chk("R6 err=BAD holds", 1'b0, BAD);
    pair_chk("R6 bad clears", 1'b1, BAD + 1);
    // R2: feedback first order
    pair_chk("R2 fb first 1", 1'b0, 2);
    pair_chk("R2 fb first 2", 1'b0, 1);
    // R5: mid restarts run before lock
    pair_chk("R5 mid resets run", 1'b0, GOOD);
    pair_chk("R5 after reset 1", 1'b1, 0);
    pair_chk("R5 after reset 2", 1'b1, 0);
    pair_chk("R5 lock again", 1'b1, 0);
    // R7: missing second edge closes the cycle as bad
    pair_chk("R7 timeout clears", 1'b1, BAD + 3);
    // R4: precise needs five
    precise = 1'b1;
    for (int i = 0; i < 4; i++) pair_chk("R4 precise run", 1'b0, 1);
    check("R4 not yet after four", 1'b0);
    pair_chk("R4 fifth locks", 1'b1, 1);
    // R8: power-down clears and ignores edges
    power_down(2);
    check("R8 pd clears", 1'b0);
    precise = 1'b0;
    pair(1'b1, 0);
    pair(1'b1, 0);
    pair(1'b1, 0);
    check("R8 edges ignored in pd", 1'b0);
    @(negedge clk);
    pwr_down = 1'b0;
    pair_chk("R8 after pd 1", 1'b1, 0);
    pair_chk("R8 after pd 2", 1'b1, 0);
    check("R8 full run needed", 1'b0);

    // random mix over R2..R7
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) precise = ~precise;
      if ($urandom_range(0, 2) == 0) pair_chk("R3 R4 R6 random", $urandom_range(0, 1) == 1, $urandom_range(0, 2));
      else pair_chk("R2 R5 R7 random", $urandom_range(0, 1) == 1, $urandom_range(0, BAD + 3));
      if ($urandom_range(0, 49) == 0) begin
        power_down(3);
        check("R8 random pd", 1'b0);
        @(negedge clk);
        pwr_down = 1'b0;
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule